// File: doc/BRIEF.md
# Event Counter Unit with Overflow Interrupts

The block counts hardware events for performance monitoring. Eight 64-bit counters each watch one event chosen by an 8-bit code from a 128-wide vector of single-cycle event pulses. A counter advances by one in a cycle only when the unit is running, the counter is switched on, its chosen event fires and an external qualifier (driven by filter logic that sits outside the block) is high. One code is reserved so that a counter advances on every clock cycle.

Software reaches the block through a plain 32-bit register port with a write strobe and a combinational read path. Every 64-bit counter shows up as two 32-bit words and either word can be loaded. When a counter wraps from all ones to zero it latches a pending bit. A per-counter mask decides whether that pending bit raises the single interrupt line. Pending bits are cleared by writing ones to a separate clear address.

Top module: `evt_ctr_unit`

## Requirements
- R1: After reset every counter reads zero, the run bit and all counter enables read zero, the mask register reads 0xFF (every interrupt blocked), pending status reads zero and `irq` is low.
- R2: Counter n goes up by exactly one on a clock edge when the run bit, enable bit n, the event picked by its code and `filtPass` are all high at that edge; if any of these is low it keeps its value.
- R3: Bit 0 of the control word at 0x1C00 is the run bit. While it is zero, no counter changes except through a bus write.
- R4: The enable word at 0x1C14 has bit n for counter n. Clearing one bit freezes only that counter.
- R5: Codes for counters 0..3 sit in the select word at 0x1C18 and codes for counters 4..7 sit in the one at 0x1C1C. Counter n uses bits [8*(n%4)+7 : 8*(n%4)], and a code c in 0x00..0x7F picks `evtPulse[c]`.
- R6: Code 0x09 makes a counter advance on every qualified cycle whatever `evtPulse` carries. Codes 0x80..0xFF never advance a counter.
- R7: The low word of counter n is at 0x1D00+8n and the high word is at 0x1D04+8n. A write replaces only that word, and a write on the same edge as an increment wins: the written value is stored and that increment is lost.
- R8: When a counter steps from all ones to zero, bit n of the pending status word at 0x0818 is set on that same edge.
- R9: The status word cannot be written. Writing a value to 0x081C clears the status bits where that value has a one and leaves the others alone. An overflow on the same edge as a clear of that bit leaves the bit set. Reading 0x081C gives zero.
- R10: Mask bit n at 0x0814 passes counter n's pending bit to `irq` when it is 0 and blocks it when it is 1. `irq` is high exactly when some pending bit has a zero mask bit.
- R11: The word at 0x1CF0 always reads 0x5A100200 and ignores writes. Any other address that is not mapped reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Write strobe for the register port |
| busAddr | input | 16 | Byte address of the register word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| evtPulse | input | 128 | One pulse line per event code |
| filtPass | input | 1 | Qualifier from external filter logic |
| irq | output | 1 | Overflow interrupt, active high |

## Verification
The checker watches invariants on every cycle. Counters hold while nothing is running and no write lands. A status bit can only rise after an overflow strobe, and every overflow strobe is latched. The interrupt stays quiet when everything is masked or nothing is pending. The identifier read stays fixed, and the state right after reset is correct. The bench's scenarios cover the behaviours that depend on ordering and exact counts: the reserved cycle code advancing by precisely ten over ten cycles, codes above 0x7F doing nothing, a word write beating a same-edge increment, overflow landing in the same edge as a clear, and the clear hitting only the bits it names. A behavioural model runs alongside and compares the interrupt and the word on the read port on every clock.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int NUM_CNT    = 8;
  localparam int CNT_W      = 64;
  localparam int BUS_W      = 32;
  localparam int ADDR_W     = 16;
  localparam int CODE_W     = 8;
  localparam int NUM_EVT    = 128;
  localparam int CYCLE_CODE = 9;

  localparam int CODES_PER_SEL = BUS_W / CODE_W;
  localparam int NUM_SEL       = (NUM_CNT + CODES_PER_SEL - 1) / CODES_PER_SEL;
  localparam int CNT_STRIDE    = CNT_W / 8;

  // register word offsets
  localparam int OFF_MASK  = 'h0814;
  localparam int OFF_STAT  = 'h0818;
  localparam int OFF_CLR   = 'h081C;
  localparam int OFF_CTRL  = 'h1C00;
  localparam int OFF_ENA   = 'h1C14;
  localparam int OFF_SEL   = 'h1C18;
  localparam int OFF_VER   = 'h1CF0;
  localparam int OFF_CNT   = 'h1D00;

  // strobes from register control to counter datapath
  typedef struct packed {
    logic [NUM_CNT-1:0]        wrLo;
    logic [NUM_CNT-1:0]        wrHi;
    logic [BUS_W-1:0]          wrData;
    logic [NUM_CNT-1:0]        runEn;
    logic [NUM_CNT*CODE_W-1:0] selCodes;
  } ctr_strobe_t;
endpackage

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice
  import evt_ctr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [CODE_W-1:0]  code,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic               filtPass,
  input  logic               runEn,
  input  logic               wrLo,
  input  logic               wrHi,
  input  logic [BUS_W-1:0]   wrData,
  output logic [CNT_W-1:0]   cntQ,
  output logic               ovf
);
  localparam int IDX_W = $clog2(NUM_EVT);

  logic evtHit;
  logic bump;
  logic wrAny;

  // event selection: reserved code counts cycles, out-of-range codes never hit
  always_comb begin
    if (code == CODE_W'(CYCLE_CODE)) begin
      evtHit = 1'b1;
    end else if (int'(code) < NUM_EVT) begin
      evtHit = evtPulse[code[IDX_W-1:0]];
    end else begin
      evtHit = 1'b0;
    end
  end

  assign bump  = runEn & evtHit & filtPass;
  assign wrAny = wrLo | wrHi;
  assign ovf   = bump & ~wrAny & (&cntQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (wrLo) begin
      cntQ <= {cntQ[CNT_W-1:BUS_W], wrData};
    end else if (wrHi) begin
      cntQ <= {wrData, cntQ[BUS_W-1:0]};
    end else if (bump) begin
      cntQ <= cntQ + CNT_W'(1);
    end
  end
endmodule

// File: rtl/evt_ctr_dpath.sv
module evt_ctr_dpath
  import evt_ctr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctr_strobe_t              strobe,
  input  logic [NUM_EVT-1:0]       evtPulse,
  input  logic                     filtPass,
  output logic [NUM_CNT*CNT_W-1:0] cntFlat,
  output logic [NUM_CNT-1:0]       ovfVec
);
  for (genvar n = 0; n < NUM_CNT; n++) begin : g_slice
    evt_ctr_slice uSlice (
      .clk      (clk),
      .rstN     (rstN),
      .code     (strobe.selCodes[n*CODE_W +: CODE_W]),
      .evtPulse (evtPulse),
      .filtPass (filtPass),
      .runEn    (strobe.runEn[n]),
      .wrLo     (strobe.wrLo[n]),
      .wrHi     (strobe.wrHi[n]),
      .wrData   (strobe.wrData),
      .cntQ     (cntFlat[n*CNT_W +: CNT_W]),
      .ovf      (ovfVec[n])
    );
  end
endmodule

// File: rtl/evt_ctr_ctrl.sv
module evt_ctr_ctrl
  import evt_ctr_pkg::*;
#(
  parameter logic [BUS_W-1:0] VERSION_ID = 32'h5A10_0200
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWe,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [BUS_W-1:0]         busWdata,
  output logic [BUS_W-1:0]         busRdata,
  input  logic [NUM_CNT*CNT_W-1:0] cntFlat,
  input  logic [NUM_CNT-1:0]       ovfVec,
  output ctr_strobe_t              strobe,
  output logic [NUM_CNT-1:0]       statusVec,
  output logic [NUM_CNT-1:0]       maskVec,
  output logic                     irq
);
  logic                          runQ;
  logic [NUM_CNT-1:0]            enQ;
  logic [NUM_CNT-1:0]            maskQ;
  logic [NUM_CNT-1:0]            statusQ;
  logic [NUM_CNT-1:0]            statusD;
  logic [NUM_CNT-1:0]            clrBits;
  logic [NUM_SEL-1:0][BUS_W-1:0] selQ;
  logic [NUM_CNT*CODE_W-1:0]     selFlat;

  logic hitCtrl, hitEna, hitMask, hitStat, hitClr, hitVer;
  logic [NUM_SEL-1:0] hitSel;
  logic [NUM_CNT-1:0] hitLo;
  logic [NUM_CNT-1:0] hitHi;

  // address decode
  assign hitCtrl = (busAddr == ADDR_W'(OFF_CTRL));
  assign hitEna  = (busAddr == ADDR_W'(OFF_ENA));
  assign hitMask = (busAddr == ADDR_W'(OFF_MASK));
  assign hitStat = (busAddr == ADDR_W'(OFF_STAT));
  assign hitClr  = (busAddr == ADDR_W'(OFF_CLR));
  assign hitVer  = (busAddr == ADDR_W'(OFF_VER));

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_selDec
    assign hitSel[k] = (busAddr == ADDR_W'(OFF_SEL + 4*k));
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cntDec
    assign hitLo[n] = (busAddr == ADDR_W'(OFF_CNT + CNT_STRIDE*n));
    assign hitHi[n] = (busAddr == ADDR_W'(OFF_CNT + CNT_STRIDE*n + 4));
  end

  // control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      enQ   <= '0;
      maskQ <= '1;
    end else if (busWe) begin
      if (hitCtrl) runQ  <= busWdata[0];
      if (hitEna)  enQ   <= busWdata[NUM_CNT-1:0];
      if (hitMask) maskQ <= busWdata[NUM_CNT-1:0];
    end
  end

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_selReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selQ[k] <= '0;
      end else if (busWe && hitSel[k]) begin
        selQ[k] <= busWdata;
      end
    end
  end

  // pending status: clear by write-one, overflow set wins
  assign clrBits = (busWe && hitClr) ? busWdata[NUM_CNT-1:0] : '0;
  assign statusD = (statusQ & ~clrBits) | ovfVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= statusD;
    end
  end

  // unpack per-counter codes from the packed select words
  for (genvar n = 0; n < NUM_CNT; n++) begin : g_selUnpack
    assign selFlat[n*CODE_W +: CODE_W] =
      selQ[n / CODES_PER_SEL][(n % CODES_PER_SEL)*CODE_W +: CODE_W];
  end

  always_comb begin
    strobe.wrLo     = busWe ? hitLo : '0;
    strobe.wrHi     = busWe ? hitHi : '0;
    strobe.wrData   = busWdata;
    strobe.runEn    = {NUM_CNT{runQ}} & enQ;
    strobe.selCodes = selFlat;
  end

  // read mux
  always_comb begin
    busRdata = '0;
    if (hitCtrl) busRdata[0] = runQ;
    if (hitEna)  busRdata[NUM_CNT-1:0] = enQ;
    if (hitMask) busRdata[NUM_CNT-1:0] = maskQ;
    if (hitStat) busRdata[NUM_CNT-1:0] = statusQ;
    if (hitVer)  busRdata = VERSION_ID;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (hitSel[k]) busRdata = selQ[k];
    end
    for (int n = 0; n < NUM_CNT; n++) begin
      if (hitLo[n]) busRdata = cntFlat[n*CNT_W +: BUS_W];
      if (hitHi[n]) busRdata = cntFlat[n*CNT_W + BUS_W +: BUS_W];
    end
  end

  assign statusVec = statusQ;
  assign maskVec   = maskQ;
  assign irq       = |(statusQ & ~maskQ);
endmodule

// File: rtl/evt_ctr_unit.sv
module evt_ctr_unit
  import evt_ctr_pkg::*;
#(
  parameter logic [BUS_W-1:0] VERSION_ID = 32'h5A10_0200
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BUS_W-1:0]   busWdata,
  output logic [BUS_W-1:0]   busRdata,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic               filtPass,
  output logic               irq
);
  ctr_strobe_t               strobe;
  logic [NUM_CNT*CNT_W-1:0]  cntFlat;
  logic [NUM_CNT-1:0]        ovfVec;
  logic [NUM_CNT-1:0]        statusVec;
  logic [NUM_CNT-1:0]        maskVec;

  evt_ctr_ctrl #(.VERSION_ID(VERSION_ID)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .cntFlat   (cntFlat),
    .ovfVec    (ovfVec),
    .strobe    (strobe),
    .statusVec (statusVec),
    .maskVec   (maskVec),
    .irq       (irq)
  );

  evt_ctr_dpath uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .evtPulse (evtPulse),
    .filtPass (filtPass),
    .cntFlat  (cntFlat),
    .ovfVec   (ovfVec)
  );
endmodule

// File: rtl/evt_ctr_unit_chk.sv
module evt_ctr_unit_chk
  import evt_ctr_pkg::*;
#(
  parameter logic [BUS_W-1:0] VERSION_ID = 32'h5A10_0200
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [ADDR_W-1:0]        busAddr,
  input logic [BUS_W-1:0]         busRdata,
  input logic                     irq,
  input ctr_strobe_t              strobe,
  input logic [NUM_CNT*CNT_W-1:0] cntFlat,
  input logic [NUM_CNT-1:0]       ovfVec,
  input logic [NUM_CNT-1:0]       statusVec,
  input logic [NUM_CNT-1:0]       maskVec
);
  // R1: state one edge after reset is sampled
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (cntFlat == '0 && maskVec == '1 && statusVec == '0 && !irq));

  // R3: nothing running and no word write means every counter holds
  p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runEn == '0 && strobe.wrLo == '0 && strobe.wrHi == '0) |=> $stable(cntFlat));

  // R8: every overflow strobe lands in status on the following sample
  p_ovf_sets_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfVec != '0) |=> ((statusVec & $past(ovfVec)) == $past(ovfVec)));

  // R9: status bits rise only from an overflow
  p_status_only_from_ovf_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfVec == '0) |=> ((statusVec & ~$past(statusVec)) == '0));

  // R10: interrupt quiet when all blocked or nothing pending
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '1 || statusVec == '0) |-> !irq);

  // R11: identifier word is constant
  p_version_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFF_VER)) |-> (busRdata == VERSION_ID));
endmodule

bind evt_ctr_unit evt_ctr_unit_chk #(.VERSION_ID(VERSION_ID)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRdata  (busRdata),
  .irq       (irq),
  .strobe    (strobe),
  .cntFlat   (cntFlat),
  .ovfVec    (ovfVec),
  .statusVec (statusVec),
  .maskVec   (maskVec)
);

// File: tb/tb_evt_ctr_unit.sv
module tb_evt_ctr_unit;
  localparam int HALF = 10; // 50 MHz
  localparam logic [31:0] VER    = 32'h5A10_0200;
  localparam logic [15:0] A_MASK = 16'h0814;
  localparam logic [15:0] A_STAT = 16'h0818;
  localparam logic [15:0] A_CLR  = 16'h081C;
  localparam logic [15:0] A_CTRL = 16'h1C00;
  localparam logic [15:0] A_EN   = 16'h1C14;
  localparam logic [15:0] A_SEL0 = 16'h1C18;
  localparam logic [15:0] A_SEL1 = 16'h1C1C;
  localparam logic [15:0] A_VER  = 16'h1CF0;
  localparam logic [15:0] A_CNT  = 16'h1D00;

  logic         clk = 1'b0;
  logic         rstN;
  logic         busWe;
  logic [15:0]  busAddr;
  logic [31:0]  busWdata;
  logic [31:0]  busRdata;
  logic [127:0] evtPulse;
  logic         filtPass;
  logic         irq;

  int nTests = 0;
  int nFail  = 0;
  int rot    = 0;
  bit randEvt = 1'b0;

  always #HALF clk = ~clk;

  evt_ctr_unit dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtPulse(evtPulse),
    .filtPass(filtPass), .irq(irq)
  );

  // behavioural reference model
  longint unsigned mCnt [8];
  bit        mRun;
  bit [7:0]  mEn, mMask, mStat;
  bit [31:0] mSel [2];

  always @(posedge clk) begin : model
    bit [7:0] ovf;
    bit [7:0] inc;
    bit [7:0] code;
    bit       hit;
    if (!rstN) begin
      for (int n = 0; n < 8; n++) mCnt[n] = 0;
      mRun = 0; mEn = 0; mMask = 8'hFF; mStat = 0; mSel[0] = 0; mSel[1] = 0;
    end else begin
      ovf = 0; inc = 0;
      for (int n = 0; n < 8; n++) begin
        code = mSel[n/4][8*(n%4) +: 8];
        if (code == 8'h09)     hit = 1'b1;
        else if (code < 8'h80) hit = evtPulse[code[6:0]];
        else                   hit = 1'b0;
        inc[n] = mRun && mEn[n] && hit && filtPass;
      end
      for (int n = 0; n < 8; n++) begin
        if (busWe && busAddr == A_CNT + 16'(8*n))
          mCnt[n][31:0] = busWdata;
        else if (busWe && busAddr == A_CNT + 16'(8*n + 4))
          mCnt[n][63:32] = busWdata;
        else if (inc[n]) begin
          if (mCnt[n] == 64'hFFFF_FFFF_FFFF_FFFF) ovf[n] = 1'b1;
          mCnt[n] = mCnt[n] + 1;
        end
      end
      if (busWe && busAddr == A_CLR) mStat = mStat & ~busWdata[7:0];
      mStat = mStat | ovf;
      if (busWe) begin
        case (busAddr)
          A_CTRL: mRun    = busWdata[0];
          A_EN:   mEn     = busWdata[7:0];
          A_MASK: mMask   = busWdata[7:0];
          A_SEL0: mSel[0] = busWdata;
          A_SEL1: mSel[1] = busWdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] mRead(logic [15:0] a);
    int n;
    case (a)
      A_CTRL: return {31'b0, mRun};
      A_EN:   return {24'b0, mEn};
      A_MASK: return {24'b0, mMask};
      A_STAT: return {24'b0, mStat};
      A_SEL0: return mSel[0];
      A_SEL1: return mSel[1];
      A_VER:  return VER;
      default: begin
        if (a >= A_CNT && a < A_CNT + 16'h40 && a[1:0] == 2'b00) begin
          n = int'((a - A_CNT) >> 3);
          return a[2] ? mCnt[n][63:32] : mCnt[n][31:0];
        end
        return 32'h0;
      end
    endcase
  endfunction

  function automatic string tagFor(logic [15:0] a);
    if (a >= A_CNT && a < A_CNT + 16'h40) return "R2";
    if (a == A_STAT || a == A_CLR) return "R9";
    if (a == A_MASK) return "R10";
    if (a == A_SEL0 || a == A_SEL1) return "R5";
    return "R11";
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      check(irq === (|(mStat & ~mMask)), "R10", "irq vs model",
            64'(irq), 64'(|(mStat & ~mMask)));
      check(busRdata === mRead(busAddr), tagFor(busAddr), "read port vs model",
            64'(busRdata), 64'(mRead(busAddr)));
    end
  end

  always @(negedge clk) begin
    if (randEvt) evtPulse = {$urandom(), $urandom(), $urandom(), $urandom()};
  end

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      busWe = 1'b0;
      busAddr = A_CNT + 16'(4 * (rot % 16));
      rot++;
    end
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    #2;
    v = busRdata;
  endtask

  task automatic expectRd(logic [15:0] a, logic [31:0] exp, string tag, string what);
    logic [31:0] v;
    rd(a, v);
    check(v == exp, tag, what, 64'(v), 64'(exp));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    rstN = 1'b0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    evtPulse = '0; filtPass = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectRd(A_MASK, 32'hFF, "R1", "mask after reset");
    expectRd(A_STAT, 32'h0, "R1", "status after reset");
    expectRd(A_CNT + 16'h4, 32'h0, "R1", "counter0 high after reset");
    expectRd(A_EN, 32'h0, "R1", "enables after reset");
    expectRd(A_CTRL, 32'h0, "R1", "run bit after reset");
    check(irq == 1'b0, "R1", "irq after reset", 64'(irq), 64'h0);

    // R11 identifier and unmapped reads
    expectRd(A_VER, VER, "R11", "identifier");
    expectRd(16'h1234, 32'h0, "R11", "unmapped read");
    wr(A_VER, 32'h0);
    expectRd(A_VER, VER, "R11", "identifier after write");

    // R5 select packing: c0=09 c1=05 c2=7F c3=80 / c4=33 c5=09 c6=05 c7=FF
    wr(A_SEL0, 32'h807F_0509);
    wr(A_SEL1, 32'hFF05_0933);
    expectRd(A_SEL1, 32'hFF05_0933, "R5", "second select word");
    wr(A_EN, 32'hFF);
    wr(A_CTRL, 32'h1);
    randEvt = 1'b1;
    idle(40);

    // R6 high codes never count
    expectRd(A_CNT + 16'(8*3), 32'h0, "R6", "code 0x80 counter");
    expectRd(A_CNT + 16'(8*7), 32'h0, "R6", "code 0xFF counter");

    // R6 cycle code with silent event vector; R2 event counter holds
    randEvt = 1'b0;
    #1 evtPulse = '0;
    rd(A_CNT, a); idle(9); rd(A_CNT, b);
    check(b - a == 32'd10, "R6", "cycle code over ten cycles", 64'(b - a), 64'd10);
    rd(A_CNT + 16'(8*1), a); idle(4); rd(A_CNT + 16'(8*1), b);
    check(b == a, "R2", "no pulse means hold", 64'(b), 64'(a));

    // R2 qualifier low blocks counting
    randEvt = 1'b1;
    filtPass = 1'b0;
    rd(A_CNT, a); idle(9); rd(A_CNT, b);
    check(b == a, "R2", "qualifier low holds", 64'(b), 64'(a));
    filtPass = 1'b1;

    // R3 run bit off
    wr(A_CTRL, 32'h0);
    rd(A_CNT + 16'(8*5), a); idle(9); rd(A_CNT + 16'(8*5), b);
    check(b == a, "R3", "run bit clear holds", 64'(b), 64'(a));
    wr(A_CTRL, 32'h1);

    // R4 single counter disabled
    wr(A_EN, 32'hDF);
    rd(A_CNT + 16'(8*5), a); idle(9); rd(A_CNT + 16'(8*5), b);
    check(b == a, "R4", "disabled counter holds", 64'(b), 64'(a));
    rd(A_CNT, a); idle(9); rd(A_CNT, b);
    check(b - a == 32'd10, "R4", "enabled neighbour runs", 64'(b - a), 64'd10);
    wr(A_EN, 32'hFF);

    // R7 word writes, write beats increment
    wr(A_CNT + 16'(8*5 + 4), 32'h1234_5678);
    expectRd(A_CNT + 16'(8*5 + 4), 32'h1234_5678, "R7", "high word write");
    wr(A_CNT + 16'(8*5), 32'hAAAA_0000);
    expectRd(A_CNT + 16'(8*5), 32'hAAAA_0000, "R7", "write wins over increment");
    expectRd(A_CNT + 16'(8*5), 32'hAAAA_0001, "R7", "counting resumes");
    expectRd(A_CNT + 16'(8*5 + 4), 32'h1234_5678, "R7", "high word untouched");

    // R8 wrap sets status; R10 masking
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_CNT + 16'h4, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    idle(2);
    expectRd(A_STAT, 32'h1, "R8", "status after wrap");
    check(irq == 1'b0, "R10", "masked pending", 64'(irq), 64'h0);
    expectRd(A_CNT, 32'h1, "R8", "counter restarted from zero");
    wr(A_MASK, 32'hFE);
    rd(A_STAT, a);
    check(irq == 1'b1, "R10", "unmasked pending", 64'(irq), 64'h1);

    // R9 read-only status, selective clear
    wr(A_STAT, 32'h0);
    expectRd(A_STAT, 32'h1, "R9", "status write ignored");
    wr(A_CLR, 32'h2);
    expectRd(A_STAT, 32'h1, "R9", "clear of other bit");
    expectRd(A_CLR, 32'h0, "R9", "clear address reads zero");
    wr(A_CLR, 32'h1);
    expectRd(A_STAT, 32'h0, "R9", "bit cleared");
    check(irq == 1'b0, "R10", "irq after clear", 64'(irq), 64'h0);

    // R9 overflow on the clear edge wins
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'hFFFF_FFFF);
    wr(A_CNT + 16'h4, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    wr(A_CLR, 32'h1);
    expectRd(A_STAT, 32'h1, "R9", "set beats clear");
    check(irq == 1'b1, "R10", "irq after set beats clear", 64'(irq), 64'h1);

    // R1 reset during operation
    @(negedge clk);
    busWe = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expectRd(A_MASK, 32'hFF, "R1", "mask after second reset");
    expectRd(A_CNT + 16'(8*5 + 4), 32'h0, "R1", "counter after second reset");
    check(irq == 1'b0, "R1", "irq after second reset", 64'(irq), 64'h0);

    summary();
    $finish;
  end
endmodule